// File: doc/BRIEF.md
# DDR PHY Command Injector

This block sits between a memory controller and a two-phase DDR PHY command and data interface. A small byte-wide register bus lets software take direct control of the SDRAM: it sets an address, a bank and write-data bytes for each phase, then writes a command byte to fire one SDRAM command on that phase. Read commands can also latch the data that the PHY returns after a fixed latency, and software reads it back over the same bus. This is how an initialisation sequence (precharge, mode register loads, refreshes) and simple low-level memory probes are run before the controller takes over.

A select bit in the control register hands the whole PHY interface to the hardware controller. While it is set, every PHY pin follows the controller, and command writes from software are dropped. The clock-enable pin always comes from the control register, in both modes. The PHY read data is passed to the controller unchanged at all times.

Top module: `ddr_cmd_inject`

## Requirements
- R1: After reset the select and clock-enable bits are 0, both phases show the idle pattern (all four active-low command pins at 1, both data enables at 0), and every register reads as 0.
- R2: Register word addresses: control at 0x00 (bit 0 select, bit 1 clock enable); phase p occupies a block at 0x20*(p+1) with command at +0, address high byte at +1, address low byte at +2, bank at +3, write bytes 0..7 at +8..+15 and read bytes 0..7 at +16..+23. Every writable register reads back the last value written. Unmapped addresses read 0.
- R3: With select clear, a write to a phase's command register drives that command on the phase for exactly the one cycle after the write edge; in the next cycle the phase is idle again. Command flag bits: bit 0 chip select, bit 1 write enable, bit 2 CAS, bit 3 RAS, bit 4 write-data strobe, bit 5 read capture. Each active-low command pin is the inverse of its flag.
- R4: With select clear, each phase continuously drives the address {high byte, low byte}, the low bits of its bank register, and its write bytes, with write byte b on data bits 8b+7..8b.
- R5: The write-data enable and read-data enable of a phase are high only in its command cycle and only when the matching flag (bit 4, bit 5) is set.
- R6: A command with the read-capture flag latches the PHY read data of that phase at the end of the cycle that follows its command cycle by RD_LAT cycles; read data in other cycles, or after commands without the flag, is not captured.
- R7: A command on one phase leaves the other phase idle and leaves its read bytes unchanged.
- R8: With select set, every PHY command, address, bank and data pin follows the hardware controller's inputs in the same cycle.
- R9: A command-register write made while select is set fires no command and captures no read data, also after select is cleared again.
- R10: The clock-enable pin equals the control register's bit 1, one cycle after the control write, in either mode.
- R11: The PHY read data is passed to the hardware controller unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, same cycle |
| hc_addr | input | NPHASE x ADDR_W | Controller address per phase |
| hc_bank | input | NPHASE x BANK_W | Controller bank per phase |
| hc_cs_n | input | NPHASE | Controller chip select, active low |
| hc_ras_n | input | NPHASE | Controller RAS, active low |
| hc_cas_n | input | NPHASE | Controller CAS, active low |
| hc_we_n | input | NPHASE | Controller write enable, active low |
| hc_wrdata_en | input | NPHASE | Controller write-data enable |
| hc_wrdata | input | NPHASE x 8*NBYTES | Controller write data |
| hc_rddata_en | input | NPHASE | Controller read-data enable |
| hc_rddata | output | NPHASE x 8*NBYTES | Read data returned to the controller |
| phy_cke | output | 1 | Clock enable to the PHY |
| phy_addr | output | NPHASE x ADDR_W | Address per phase |
| phy_bank | output | NPHASE x BANK_W | Bank per phase |
| phy_cs_n | output | NPHASE | Chip select, active low |
| phy_ras_n | output | NPHASE | RAS, active low |
| phy_cas_n | output | NPHASE | CAS, active low |
| phy_we_n | output | NPHASE | Write enable, active low |
| phy_wrdata_en | output | NPHASE | Write-data enable |
| phy_wrdata | output | NPHASE x 8*NBYTES | Write data |
| phy_rddata_en | output | NPHASE | Read-data enable |
| phy_rddata | input | NPHASE x 8*NBYTES | Read data from the PHY |

## Verification
A register write is sampled on one rising edge and its effect (a command pulse, a new clock-enable level) is due in the cycle that follows, with the idle pattern due one cycle later; the driver records the cycle number of the write edge and pushes expected pin values tagged with those later cycle numbers, and the monitor compares them on falling edges only in the tagged cycle. Read capture is due at the edge closing cycle write+1+RD_LAT, so the bench presents the pattern on the PHY read data in exactly that cycle and garbage around it, then reads the bytes back. The controller route and register readback are combinational and are checked one nanosecond after the inputs change, away from any edge.

// File: rtl/ddrci_pkg.sv
package ddrci_pkg;

    // control register bits
    localparam int CTRL_SEL = 0;
    localparam int CTRL_CKE = 1;

    // offsets inside one phase block
    localparam int OFS_CMD   = 0;
    localparam int OFS_AHI   = 1;
    localparam int OFS_ALO   = 2;
    localparam int OFS_BANK  = 3;
    localparam int OFS_WR    = 8;
    localparam int OFS_RD    = 16;
    localparam int PHASE_STRIDE = 32;
    localparam int NFLAG     = 6;

    // command flags, bit 0 is chip select
    typedef struct packed {
        logic rdc;
        logic wrd;
        logic ras;
        logic cas;
        logic we;
        logic cs;
    } cmd_flags_t;

    function automatic int phase_base(int p);
        return PHASE_STRIDE * (p + 1);
    endfunction

endpackage

// File: rtl/ddrci_regs.sv
module ddrci_regs
    import ddrci_pkg::*;
#(
    parameter int NPHASE = 2,
    parameter int NBYTES = 8,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int REG_AW = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 reg_wr,
    input  logic [REG_AW-1:0]                    reg_addr,
    input  logic [7:0]                           reg_wdata,
    output logic [7:0]                           reg_rdata,
    input  logic [NPHASE-1:0][NBYTES-1:0][7:0]   cap_bytes,
    output logic                                 sel,
    output logic                                 cke,
    output cmd_flags_t [NPHASE-1:0]              sw_flags,
    output logic [NPHASE-1:0][ADDR_W-1:0]        sw_addr,
    output logic [NPHASE-1:0][BANK_W-1:0]        sw_bank,
    output logic [NPHASE-1:0][NBYTES*8-1:0]      sw_wrdata
);

    typedef struct packed {
        logic                               sel;
        logic                               cke;
        logic [NPHASE-1:0][7:0]             cmd;
        logic [NPHASE-1:0][7:0]             ahi;
        logic [NPHASE-1:0][7:0]             alo;
        logic [NPHASE-1:0][7:0]             bnk;
        logic [NPHASE-1:0][NBYTES-1:0][7:0] wr;
        logic [NPHASE-1:0]                  fire;
    } st_t;

    st_t s_d, s_q;
    int  a;

    assign a = int'(reg_addr);

    always_comb begin
        s_d      = s_q;
        s_d.fire = '0;
        if (reg_wr) begin
            if (a == 0) begin
                s_d.sel = reg_wdata[CTRL_SEL];
                s_d.cke = reg_wdata[CTRL_CKE];
            end
            for (int p = 0; p < NPHASE; p++) begin
                if (a == phase_base(p) + OFS_CMD) begin
                    s_d.cmd[p]  = reg_wdata;
                    s_d.fire[p] = !s_q.sel;
                end
                if (a == phase_base(p) + OFS_AHI)  s_d.ahi[p] = reg_wdata;
                if (a == phase_base(p) + OFS_ALO)  s_d.alo[p] = reg_wdata;
                if (a == phase_base(p) + OFS_BANK) s_d.bnk[p] = reg_wdata;
                for (int b = 0; b < NBYTES; b++) begin
                    if (a == phase_base(p) + OFS_WR + b) s_d.wr[p][b] = reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // readback, same cycle as the address
    always_comb begin
        reg_rdata = '0;
        if (a == 0) reg_rdata = 8'({s_q.cke, s_q.sel});
        for (int p = 0; p < NPHASE; p++) begin
            if (a == phase_base(p) + OFS_CMD)  reg_rdata = s_q.cmd[p];
            if (a == phase_base(p) + OFS_AHI)  reg_rdata = s_q.ahi[p];
            if (a == phase_base(p) + OFS_ALO)  reg_rdata = s_q.alo[p];
            if (a == phase_base(p) + OFS_BANK) reg_rdata = s_q.bnk[p];
            for (int b = 0; b < NBYTES; b++) begin
                if (a == phase_base(p) + OFS_WR + b) reg_rdata = s_q.wr[p][b];
                if (a == phase_base(p) + OFS_RD + b) reg_rdata = cap_bytes[p][b];
            end
        end
    end

    assign sel = s_q.sel;
    assign cke = s_q.cke;

    always_comb begin
        for (int p = 0; p < NPHASE; p++) begin
            sw_flags[p]  = s_q.fire[p] ? cmd_flags_t'(s_q.cmd[p][NFLAG-1:0]) : '0;
            sw_addr[p]   = ADDR_W'({s_q.ahi[p], s_q.alo[p]});
            sw_bank[p]   = s_q.bnk[p][BANK_W-1:0];
            sw_wrdata[p] = s_q.wr[p];
        end
    end

endmodule

// File: rtl/ddrci_capture.sv
module ddrci_capture #(
    parameter int NPHASE = 2,
    parameter int NBYTES = 8,
    parameter int RD_LAT = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NPHASE-1:0]                  rd_fire,
    input  logic [NPHASE-1:0][NBYTES*8-1:0]    phy_rddata,
    output logic [NPHASE-1:0][NBYTES-1:0][7:0] cap_bytes
);

    typedef struct packed {
        logic [NPHASE-1:0][RD_LAT-1:0]      pipe;
        logic [NPHASE-1:0][NBYTES-1:0][7:0] held;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NPHASE; p++) begin
            for (int i = 0; i < RD_LAT; i++) begin
                if (i == 0) s_d.pipe[p][i] = rd_fire[p];
                else        s_d.pipe[p][i] = s_q.pipe[p][i-1];
            end
            if (s_q.pipe[p][RD_LAT-1]) s_d.held[p] = phy_rddata[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap_bytes = s_q.held;

endmodule

// File: rtl/ddrci_route.sv
module ddrci_route
    import ddrci_pkg::*;
#(
    parameter int NPHASE = 2,
    parameter int NBYTES = 8,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3
) (
    input  logic                             sel,
    input  cmd_flags_t [NPHASE-1:0]          sw_flags,
    input  logic [NPHASE-1:0][ADDR_W-1:0]    sw_addr,
    input  logic [NPHASE-1:0][BANK_W-1:0]    sw_bank,
    input  logic [NPHASE-1:0][NBYTES*8-1:0]  sw_wrdata,
    input  logic [NPHASE-1:0][ADDR_W-1:0]    hc_addr,
    input  logic [NPHASE-1:0][BANK_W-1:0]    hc_bank,
    input  logic [NPHASE-1:0]                hc_cs_n,
    input  logic [NPHASE-1:0]                hc_ras_n,
    input  logic [NPHASE-1:0]                hc_cas_n,
    input  logic [NPHASE-1:0]                hc_we_n,
    input  logic [NPHASE-1:0]                hc_wrdata_en,
    input  logic [NPHASE-1:0][NBYTES*8-1:0]  hc_wrdata,
    input  logic [NPHASE-1:0]                hc_rddata_en,
    output logic [NPHASE-1:0][ADDR_W-1:0]    phy_addr,
    output logic [NPHASE-1:0][BANK_W-1:0]    phy_bank,
    output logic [NPHASE-1:0]                phy_cs_n,
    output logic [NPHASE-1:0]                phy_ras_n,
    output logic [NPHASE-1:0]                phy_cas_n,
    output logic [NPHASE-1:0]                phy_we_n,
    output logic [NPHASE-1:0]                phy_wrdata_en,
    output logic [NPHASE-1:0][NBYTES*8-1:0]  phy_wrdata,
    output logic [NPHASE-1:0]                phy_rddata_en
);

    always_comb begin
        if (sel) begin
            phy_addr      = hc_addr;
            phy_bank      = hc_bank;
            phy_cs_n      = hc_cs_n;
            phy_ras_n     = hc_ras_n;
            phy_cas_n     = hc_cas_n;
            phy_we_n      = hc_we_n;
            phy_wrdata_en = hc_wrdata_en;
            phy_wrdata    = hc_wrdata;
            phy_rddata_en = hc_rddata_en;
        end else begin
            for (int p = 0; p < NPHASE; p++) begin
                phy_addr[p]      = sw_addr[p];
                phy_bank[p]      = sw_bank[p];
                phy_cs_n[p]      = ~sw_flags[p].cs;
                phy_ras_n[p]     = ~sw_flags[p].ras;
                phy_cas_n[p]     = ~sw_flags[p].cas;
                phy_we_n[p]      = ~sw_flags[p].we;
                phy_wrdata_en[p] = sw_flags[p].wrd;
                phy_wrdata[p]    = sw_wrdata[p];
                phy_rddata_en[p] = sw_flags[p].rdc;
            end
        end
    end

endmodule

// File: rtl/ddr_cmd_inject.sv
module ddr_cmd_inject
    import ddrci_pkg::*;
#(
    parameter int NPHASE = 2,
    parameter int NBYTES = 8,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int RD_LAT = 4,
    parameter int REG_AW = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic [REG_AW-1:0]                reg_addr,
    input  logic [7:0]                       reg_wdata,
    output logic [7:0]                       reg_rdata,
    input  logic [NPHASE-1:0][ADDR_W-1:0]    hc_addr,
    input  logic [NPHASE-1:0][BANK_W-1:0]    hc_bank,
    input  logic [NPHASE-1:0]                hc_cs_n,
    input  logic [NPHASE-1:0]                hc_ras_n,
    input  logic [NPHASE-1:0]                hc_cas_n,
    input  logic [NPHASE-1:0]                hc_we_n,
    input  logic [NPHASE-1:0]                hc_wrdata_en,
    input  logic [NPHASE-1:0][NBYTES*8-1:0]  hc_wrdata,
    input  logic [NPHASE-1:0]                hc_rddata_en,
    output logic [NPHASE-1:0][NBYTES*8-1:0]  hc_rddata,
    output logic                             phy_cke,
    output logic [NPHASE-1:0][ADDR_W-1:0]    phy_addr,
    output logic [NPHASE-1:0][BANK_W-1:0]    phy_bank,
    output logic [NPHASE-1:0]                phy_cs_n,
    output logic [NPHASE-1:0]                phy_ras_n,
    output logic [NPHASE-1:0]                phy_cas_n,
    output logic [NPHASE-1:0]                phy_we_n,
    output logic [NPHASE-1:0]                phy_wrdata_en,
    output logic [NPHASE-1:0][NBYTES*8-1:0]  phy_wrdata,
    output logic [NPHASE-1:0]                phy_rddata_en,
    input  logic [NPHASE-1:0][NBYTES*8-1:0]  phy_rddata
);

    logic                               sel_w;
    cmd_flags_t [NPHASE-1:0]            sw_flags;
    logic [NPHASE-1:0][ADDR_W-1:0]      sw_addr;
    logic [NPHASE-1:0][BANK_W-1:0]      sw_bank;
    logic [NPHASE-1:0][NBYTES*8-1:0]    sw_wrdata;
    logic [NPHASE-1:0][NBYTES-1:0][7:0] cap_bytes;
    logic [NPHASE-1:0]                  rd_fire;

    ddrci_regs #(
        .NPHASE(NPHASE), .NBYTES(NBYTES), .ADDR_W(ADDR_W),
        .BANK_W(BANK_W), .REG_AW(REG_AW)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_bytes (cap_bytes),
        .sel       (sel_w),
        .cke       (phy_cke),
        .sw_flags  (sw_flags),
        .sw_addr   (sw_addr),
        .sw_bank   (sw_bank),
        .sw_wrdata (sw_wrdata)
    );

    always_comb begin
        for (int p = 0; p < NPHASE; p++) rd_fire[p] = sw_flags[p].rdc;
    end

    ddrci_capture #(
        .NPHASE(NPHASE), .NBYTES(NBYTES), .RD_LAT(RD_LAT)
    ) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire    (rd_fire),
        .phy_rddata (phy_rddata),
        .cap_bytes  (cap_bytes)
    );

    ddrci_route #(
        .NPHASE(NPHASE), .NBYTES(NBYTES), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) i_route (
        .sel           (sel_w),
        .sw_flags      (sw_flags),
        .sw_addr       (sw_addr),
        .sw_bank       (sw_bank),
        .sw_wrdata     (sw_wrdata),
        .hc_addr       (hc_addr),
        .hc_bank       (hc_bank),
        .hc_cs_n       (hc_cs_n),
        .hc_ras_n      (hc_ras_n),
        .hc_cas_n      (hc_cas_n),
        .hc_we_n       (hc_we_n),
        .hc_wrdata_en  (hc_wrdata_en),
        .hc_wrdata     (hc_wrdata),
        .hc_rddata_en  (hc_rddata_en),
        .phy_addr      (phy_addr),
        .phy_bank      (phy_bank),
        .phy_cs_n      (phy_cs_n),
        .phy_ras_n     (phy_ras_n),
        .phy_cas_n     (phy_cas_n),
        .phy_we_n      (phy_we_n),
        .phy_wrdata_en (phy_wrdata_en),
        .phy_wrdata    (phy_wrdata),
        .phy_rddata_en (phy_rddata_en)
    );

    assign hc_rddata = phy_rddata;

endmodule

// File: rtl/ddrci_checker.sv
module ddrci_checker
    import ddrci_pkg::*;
#(
    parameter int NPHASE = 2,
    parameter int ADDR_W = 16,
    parameter int REG_AW = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [REG_AW-1:0]             reg_addr,
    input logic [7:0]                    reg_wdata,
    input logic                          sel_w,
    input logic [NPHASE-1:0][ADDR_W-1:0] hc_addr,
    input logic [NPHASE-1:0]             hc_cs_n,
    input logic                          phy_cke,
    input logic [NPHASE-1:0][ADDR_W-1:0] phy_addr,
    input logic [NPHASE-1:0]             phy_cs_n,
    input logic [NPHASE-1:0]             phy_wrdata_en,
    input logic [NPHASE-1:0]             phy_rddata_en
);

    for (genvar p = 0; p < NPHASE; p++) begin : g_ph
        // R3: a software command only follows a write to that phase's command register
        a_r3_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_w && !phy_cs_n[p]) |->
                $past(reg_wr && int'(reg_addr) == phase_base(p) + OFS_CMD));

        // R5: no bus write in the previous cycle means the phase idles
        a_r5_idle_without_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_w && !$past(reg_wr)) |->
                (phy_cs_n[p] && !phy_wrdata_en[p] && !phy_rddata_en[p]));

        // R8: controller owns the pins when selected
        a_r8_controller_route: assert property (@(posedge clk) disable iff (!rst_n)
            sel_w |-> (phy_addr[p] == hc_addr[p] && phy_cs_n[p] == hc_cs_n[p]));
    end

    // R10: clock enable takes the written bit one cycle later
    a_r10_cke_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_addr == '0) |-> (phy_cke == $past(reg_wdata[CTRL_CKE])));

    // R10: clock enable only moves after a control write
    a_r10_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr && reg_addr == '0) |-> $stable(phy_cke));

endmodule

bind ddr_cmd_inject ddrci_checker #(
    .NPHASE(NPHASE), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
) i_ddrci_checker (.*);

// File: tb/test_ddr_cmd_inject.sv
`timescale 1ns/1ps
module test_ddr_cmd_inject;

    localparam int NPHASE = 2;
    localparam int NBYTES = 8;
    localparam int ADDR_W = 16;
    localparam int BANK_W = 3;
    localparam int RD_LAT = 4;
    localparam int REG_AW = 7;
    localparam int DW     = NBYTES * 8;
    localparam logic [5:0] IDLE = 6'b111100;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                         rst_n;
    logic                         reg_wr;
    logic [REG_AW-1:0]            reg_addr;
    logic [7:0]                   reg_wdata;
    logic [7:0]                   reg_rdata;
    logic [NPHASE-1:0][ADDR_W-1:0] hc_addr;
    logic [NPHASE-1:0][BANK_W-1:0] hc_bank;
    logic [NPHASE-1:0]            hc_cs_n, hc_ras_n, hc_cas_n, hc_we_n;
    logic [NPHASE-1:0]            hc_wrdata_en, hc_rddata_en;
    logic [NPHASE-1:0][DW-1:0]    hc_wrdata, hc_rddata;
    logic                         phy_cke;
    logic [NPHASE-1:0][ADDR_W-1:0] phy_addr;
    logic [NPHASE-1:0][BANK_W-1:0] phy_bank;
    logic [NPHASE-1:0]            phy_cs_n, phy_ras_n, phy_cas_n, phy_we_n;
    logic [NPHASE-1:0]            phy_wrdata_en, phy_rddata_en;
    logic [NPHASE-1:0][DW-1:0]    phy_wrdata, phy_rddata;

    ddr_cmd_inject #(
        .NPHASE(NPHASE), .NBYTES(NBYTES), .ADDR_W(ADDR_W),
        .BANK_W(BANK_W), .RD_LAT(RD_LAT), .REG_AW(REG_AW)
    ) i_ddr_cmd_inject (.*);

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          cyc;
        int          kind;   // 0/1 phase pins, 2 clock enable
        logic [63:0] exp;
        string       req;
    } item_t;
    item_t sbq[$];

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] probe(int k);
        if (k == 2) return {63'd0, phy_cke};
        return {58'd0, phy_cs_n[k], phy_ras_n[k], phy_cas_n[k], phy_we_n[k],
                phy_wrdata_en[k], phy_rddata_en[k]};
    endfunction

    function automatic logic [5:0] pin_exp(logic [7:0] f);
        return {~f[0], ~f[3], ~f[2], ~f[1], f[4], f[5]};
    endfunction

    function automatic logic [REG_AW-1:0] base(int p);
        return REG_AW'(32 * (p + 1));
    endfunction

    // monitor: compares queued expectations in their due cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
                item_t it;
                it = sbq.pop_front();
                if (it.cyc < cyc) check(it.req, 64'hBAD, it.exp);
                else              check(it.req, probe(it.kind), it.exp);
            end
        end
    end

    task automatic bus_write(logic [REG_AW-1:0] a, logic [7:0] d, output int c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; c = cyc;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_ctrl(logic sel, logic cke);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = '0; reg_wdata = {6'd0, cke, sel};
        sbq.push_back('{cyc + 1, 2, {63'd0, cke}, "R10"});
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic command(int p, logic [7:0] f, bit live, output int c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = base(p); reg_wdata = f; c = cyc;
        if (live) begin
            sbq.push_back('{c + 1, p, {58'd0, pin_exp(f)}, "R3/R5"});
            sbq.push_back('{c + 1, 1 - p, {58'd0, IDLE}, "R7"});
            sbq.push_back('{c + 2, p, {58'd0, IDLE}, "R3"});
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_check(logic [REG_AW-1:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, {56'd0, reg_rdata}, {56'd0, exp});
    endtask

    // present pat on phase p only in cycle t
    task automatic serve_read(int p, int t, logic [DW-1:0] pat);
        while (cyc < t) @(negedge clk);
        phy_rddata[p] = pat;
        @(negedge clk);
        phy_rddata[p] = {NBYTES{8'hE7}};
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    localparam logic [DW-1:0] PAT1 = 64'h8877665544332211;
    localparam logic [DW-1:0] PAT2 = 64'h0F0E0D0C0B0A0908;

    initial begin
        int c;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        hc_addr = '0; hc_bank = '0;
        hc_cs_n = '1; hc_ras_n = '1; hc_cas_n = '1; hc_we_n = '1;
        hc_wrdata_en = '0; hc_rddata_en = '0; hc_wrdata = '0;
        phy_rddata = {NPHASE{ {NBYTES{8'hE7}} }};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 phase0 idle", probe(0), {58'd0, IDLE});
        check("R1 phase1 idle", probe(1), {58'd0, IDLE});
        check("R1 cke low", probe(2), 64'd0);
        read_check(7'h00, 8'h00, "R1 control");
        read_check(7'h21, 8'h00, "R1 addr high");
        read_check(7'h30, 8'h00, "R1 read byte");

        // R10 clock enable on
        set_ctrl(1'b0, 1'b1);

        // R2 / R4 phase 0 address and bank
        bus_write(7'h21, 8'h12, c);
        bus_write(7'h22, 8'h34, c);
        bus_write(7'h23, 8'h05, c);
        read_check(7'h00, 8'h02, "R2 control readback");
        read_check(7'h21, 8'h12, "R2 addr high readback");
        read_check(7'h22, 8'h34, "R2 addr low readback");
        read_check(7'h23, 8'h05, "R2 bank readback");
        read_check(7'h07, 8'h00, "R2 unmapped");
        read_check(7'h24, 8'h00, "R2 unmapped in block");
        check("R4 phase0 address", 64'(phy_addr[0]), 64'h1234);
        check("R4 phase0 bank", 64'(phy_bank[0]), 64'd5);

        // R3 precharge and activate on phase 0
        command(0, 8'h0B, 1'b1, c);
        command(0, 8'h09, 1'b1, c);
        read_check(7'h20, 8'h09, "R2 command readback");
        read_check(7'h30, 8'h00, "R6 no capture without flag");

        // R4 / R5 write on phase 1
        for (int b = 0; b < NBYTES; b++) bus_write(REG_AW'(7'h48 + b), 8'hF0 + 8'(b), c);
        bus_write(7'h41, 8'h00, c);
        bus_write(7'h42, 8'h40, c);
        check("R4 phase1 write data", phy_wrdata[1], 64'hF7F6F5F4F3F2F1F0);
        check("R4 phase1 address", 64'(phy_addr[1]), 64'h0040);
        read_check(7'h4B, 8'hF3, "R2 write byte readback");
        command(1, 8'h17, 1'b1, c);

        // R6 read capture on phase 0
        command(0, 8'h25, 1'b1, c);
        serve_read(0, c + 1 + RD_LAT, PAT1);
        read_check(7'h30, 8'h11, "R6 byte0 captured");
        read_check(7'h37, 8'h88, "R6 byte7 captured");
        read_check(7'h33, 8'h44, "R6 byte3 captured");
        read_check(7'h50, 8'h00, "R7 other phase untouched");

        // R8 controller route
        set_ctrl(1'b1, 1'b1);
        @(negedge clk);
        hc_addr[0] = 16'hBEEF; hc_bank[1] = 3'd6;
        hc_cs_n = 2'b10; hc_ras_n = 2'b01; hc_wrdata_en = 2'b10;
        hc_wrdata[1] = 64'h0123456789ABCDEF;
        #1;
        check("R8 address", 64'(phy_addr[0]), 64'hBEEF);
        check("R8 bank", 64'(phy_bank[1]), 64'd6);
        check("R8 cs", 64'(phy_cs_n), 64'd2);
        check("R8 ras", 64'(phy_ras_n), 64'd1);
        check("R8 wrdata_en", 64'(phy_wrdata_en), 64'd2);
        check("R8 wrdata", phy_wrdata[1], 64'h0123456789ABCDEF);
        check("R10 cke in controller mode", probe(2), 64'd1);

        // R11 read data pass-through
        phy_rddata[1] = 64'hCAFEF00D12345678;
        #1;
        check("R11 phase1 pass", hc_rddata[1], 64'hCAFEF00D12345678);
        check("R11 phase0 pass", hc_rddata[0], phy_rddata[0]);

        // R9 command while controller selected is dropped
        hc_cs_n = '1; hc_ras_n = '1; hc_wrdata_en = '0;
        command(0, 8'h25, 1'b0, c);
        serve_read(0, c + 1 + RD_LAT, PAT2);
        set_ctrl(1'b0, 1'b1);
        @(negedge clk);
        check("R9 phase0 idle after return", probe(0), {58'd0, IDLE});
        read_check(7'h30, 8'h11, "R9 buffer kept");
        read_check(7'h36, 8'h77, "R9 buffer kept high");

        // R10 clock enable off
        set_ctrl(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", 64'(sbq.size()), 64'd0);
        finish_run();
    end

endmodule